// File: doc/BRIEF.md
# SpaceWire Receive Packet Channel Router

This block sits behind the receive character FIFO of a SpaceWire link. It pulls N-Chars out of that FIFO one at a time and decides, once per packet, where the packet belongs. The first character of every packet is taken as its logical address. That address is compared under a mask against a per-channel address/mask pair, or against a shared default pair, for each enabled DMA channel. It is also compared against the default pair on behalf of the RMAP target.

The first one to three characters are held in a small header buffer until the routing decision can be made. They are then replayed in order to the chosen destination. The rest of the packet streams straight through. A destination index of `NCH` means the RMAP target, and lower values name a DMA channel. The end of each forwarded packet is signalled by a separate end beat that carries an error flag for EEP. A packet that has no destination, or that is too short, produces no output at all. It is read and dropped up to and including its end marker.

Downstream logic (descriptor engines, memory writers, the RMAP command executor) consumes the tagged byte stream without back-pressure.

Top module: `spw_rx_steer`

## Requirements
- R1: Among channels whose enable bit is 1 and whose selected pair matches, the packet goes to the lowest-numbered one. A channel whose enable bit is 0 never receives data.
- R2: An address matches a pair when `((addr ^ pair_addr) & ~pair_mask) == 0`, so a 1 in the mask removes that bit position from the comparison.
- R3: A channel whose own-pair bit is 1 is matched with its own address/mask fields (channel i uses bits [8i+7:8i]). With the bit at 0, the channel is matched with the default pair.
- R4: A packet is an RMAP command when the RMAP target is enabled, the second character equals 0x01, and bit 6 of the third character is 1. An RMAP command whose address matches the default pair goes to the RMAP target (destination index NCH), even when a channel also matches.
- R5: An RMAP command that misses the default pair goes to the first matching channel. If no channel matches, it still goes to the RMAP target.
- R6: A packet that is not sent to a channel or to the RMAP target produces no data beat and no end beat. Its characters are consumed up to and including the end marker.
- R7: A forwarded packet appears as one data beat per non-marker character, in arrival order and starting with the address. It is followed by one end beat with `out_valid` low. `out_end_err` on that beat is 1 for EEP and 0 for EOP.
- R8: A packet with fewer than 2 non-marker characters is discarded. When promiscuous mode is on, 1 character is enough. A packet consisting of a marker alone produces nothing.
- R9: With the RMAP target enabled, a packet whose second character is 0x01 needs at least 3 non-marker characters, or it is discarded.
- R10: The destination is decided once per packet and is the same on every beat of that packet, including its end beat. After an end beat there is at least one idle output cycle.
- R11: While reset is high and in the first cycle after it, `out_valid` and `out_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxf_valid | input | 1 | FIFO holds a character |
| rxf_data | input | 8 | Data character at the FIFO head |
| rxf_marker | input | 1 | FIFO head is an end marker (EOP or EEP) |
| rxf_err | input | 1 | With rxf_marker: 1 for EEP, 0 for EOP |
| rxf_rd | output | 1 | Pops the FIFO head at this clock edge |
| cfg_chan_en | input | NCH | Per-channel enable |
| cfg_chan_own | input | NCH | Per-channel select of its own address pair |
| cfg_chan_addr | input | 8*NCH | Channel addresses, channel i in bits [8i+7:8i] |
| cfg_chan_mask | input | 8*NCH | Channel masks, same layout |
| cfg_def_addr | input | 8 | Default address |
| cfg_def_mask | input | 8 | Default mask |
| cfg_rmap_en | input | 1 | RMAP target enabled |
| cfg_promisc | input | 1 | Promiscuous mode (1-character minimum) |
| out_valid | output | 1 | Data beat present |
| out_data | output | 8 | Data byte |
| out_end | output | 1 | End-of-packet beat |
| out_end_err | output | 1 | End beat came from EEP |
| out_dest | output | $clog2(NCH+1) | Destination: channel index, or NCH for the RMAP target |

## Verification
Every logical address from 0 to 255 is sent under four configurations, giving 1,024 packets in total:
- mixed own and default pairs;
- overlapping own ranges behind a disabled channel, in promiscuous mode with RMAP off;
- no enabled channel;
- all channels on the default pair.

Packet length, protocol ID, command bit and terminator type are all derived from the address. Together they exercise zero-, one-, two- and three-character packets, RMAP commands against replies, and EEP against EOP. The sweep separates lowest-index priority from mere matching, own-pair from default-pair selection, and target priority on a default hit from the fallback to the target on a miss. It also separates the RMAP 3-character rule from the plain 2-character rule. Random FIFO gaps check that the header replay and the streamed tail join without reordering or losing bytes.

// File: rtl/spw_steer_pkg.sv
package spw_steer_pkg;

    typedef enum logic [2:0] {
        ST_HEAD,
        ST_DECIDE,
        ST_REPLAY,
        ST_END,
        ST_STREAM,
        ST_DROP
    } steer_state_e;

    localparam logic [7:0]  RMAP_PROTO_ID = 8'h01;
    localparam int unsigned CMD_FLAG_BIT  = 6;
    localparam int unsigned HDR_DEPTH     = 3;

    typedef struct packed {
        logic keep;
        logic to_target;
    } verdict_t;

    function automatic logic masked_match(input logic [7:0] rx,
                                          input logic [7:0] ref_a,
                                          input logic [7:0] msk);
        return ((rx ^ ref_a) & ~msk) == 8'h00;
    endfunction

endpackage

// File: rtl/steer_addr_match.sv
module steer_addr_match
    import spw_steer_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input  logic [7:0]       addr,
    input  logic [NCH-1:0]   chan_en,
    input  logic [NCH-1:0]   chan_own,
    input  logic [NCH*8-1:0] chan_addr,
    input  logic [NCH*8-1:0] chan_mask,
    input  logic [7:0]       def_addr,
    input  logic [7:0]       def_mask,
    output logic [NCH-1:0]   chan_hit,
    output logic             def_hit
);

    assign def_hit = masked_match(addr, def_addr, def_mask);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic own_hit;
        assign own_hit     = masked_match(addr, chan_addr[g*8 +: 8], chan_mask[g*8 +: 8]);
        assign chan_hit[g] = chan_en[g] && (chan_own[g] ? own_hit : def_hit);
    end

endmodule

// File: rtl/steer_first_pick.sv
module steer_first_pick #(
    parameter int unsigned NCH = 4,
    parameter int unsigned IW  = 3
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [IW-1:0]  idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/steer_hdr_buf.sv
module steer_hdr_buf #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 3,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               din,
    output logic [CW-1:0]              cnt,
    output logic [DEPTH-1:0][W-1:0]    ents
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (push) begin
            ents[cnt] <= din;
            cnt       <= cnt + 1'b1;
        end
    end

    // R7
    hdr_room_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt < CW'(DEPTH)));

endmodule

// File: rtl/spw_rx_steer.sv
module spw_rx_steer
    import spw_steer_pkg::*;
#(
    parameter int unsigned NCH = 4,
    localparam int unsigned DW = $clog2(NCH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxf_valid,
    input  logic [7:0]       rxf_data,
    input  logic             rxf_marker,
    input  logic             rxf_err,
    output logic             rxf_rd,
    input  logic [NCH-1:0]   cfg_chan_en,
    input  logic [NCH-1:0]   cfg_chan_own,
    input  logic [NCH*8-1:0] cfg_chan_addr,
    input  logic [NCH*8-1:0] cfg_chan_mask,
    input  logic [7:0]       cfg_def_addr,
    input  logic [7:0]       cfg_def_mask,
    input  logic             cfg_rmap_en,
    input  logic             cfg_promisc,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_end,
    output logic             out_end_err,
    output logic [DW-1:0]    out_dest
);

    localparam int unsigned   HCW        = $clog2(HDR_DEPTH + 1);
    localparam logic [DW-1:0] TARGET_IDX = DW'(NCH);

    steer_state_e st_q, st_d;

    logic [HCW-1:0]                 hcnt;
    logic [HDR_DEPTH-1:0][7:0]      hb;
    logic                           ended_q, err_q;
    logic [HCW-1:0]                 rp_q;
    logic [DW-1:0]                  dest_q;

    logic                           take_d, take_m, push, clr, head_ready;
    logic [HCW-1:0]                 next_cnt;

    logic [NCH-1:0]                 hit;
    logic                           def_hit, any_hit;
    logic [DW-1:0]                  first_idx;

    logic                           proto_rmap, is_cmd, len_ok;
    verdict_t                       vd;
    logic [DW-1:0]                  vd_dest;

    logic                           ov_q, oe_q, oerr_q;
    logic [7:0]                     od_q;
    logic [DW-1:0]                  odest_q;

    // ---------------- FIFO side ----------------
    assign rxf_rd = rxf_valid &&
                    (st_q == ST_HEAD || st_q == ST_STREAM || st_q == ST_DROP);
    assign take_d = rxf_rd && !rxf_marker;
    assign take_m = rxf_rd &&  rxf_marker;

    // ---------------- header capture ----------------
    assign push     = (st_q == ST_HEAD) && take_d;
    assign next_cnt = hcnt + 1'b1;
    assign clr      = (st_d == ST_HEAD) && (st_q != ST_HEAD);

    // Enough characters seen: 3, or 2 when the protocol ID cannot make it RMAP
    assign head_ready = push &&
        ((next_cnt == HCW'(HDR_DEPTH)) ||
         ((next_cnt == HCW'(2)) && !(cfg_rmap_en && (rxf_data == RMAP_PROTO_ID))));

    steer_hdr_buf #(
        .W     (8),
        .DEPTH (HDR_DEPTH)
    ) u_hdr (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .push (push),
        .din  (rxf_data),
        .cnt  (hcnt),
        .ents (hb)
    );

    // ---------------- address comparison ----------------
    steer_addr_match #(
        .NCH (NCH)
    ) u_match (
        .addr      (hb[0]),
        .chan_en   (cfg_chan_en),
        .chan_own  (cfg_chan_own),
        .chan_addr (cfg_chan_addr),
        .chan_mask (cfg_chan_mask),
        .def_addr  (cfg_def_addr),
        .def_mask  (cfg_def_mask),
        .chan_hit  (hit),
        .def_hit   (def_hit)
    );

    steer_first_pick #(
        .NCH (NCH),
        .IW  (DW)
    ) u_pick (
        .req (hit),
        .any (any_hit),
        .idx (first_idx)
    );

    // ---------------- routing verdict ----------------
    assign proto_rmap = cfg_rmap_en && (hcnt >= HCW'(2)) && (hb[1] == RMAP_PROTO_ID);
    assign is_cmd     = proto_rmap && (hcnt == HCW'(3)) && hb[2][CMD_FLAG_BIT];

    always_comb begin
        if (!ended_q)
            len_ok = 1'b1;
        else if (hcnt == HCW'(1))
            len_ok = cfg_promisc;
        else
            len_ok = !proto_rmap;
    end

    always_comb begin
        vd      = '0;
        vd_dest = first_idx;
        if (is_cmd && def_hit) begin
            vd.to_target = 1'b1;
            vd_dest      = TARGET_IDX;
        end else if (any_hit) begin
            vd_dest = first_idx;
        end else if (is_cmd) begin
            vd.to_target = 1'b1;
            vd_dest      = TARGET_IDX;
        end
        vd.keep = len_ok && (vd.to_target || any_hit);
    end

    // ---------------- control ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HEAD: begin
                if (head_ready)
                    st_d = ST_DECIDE;
                else if (take_m && (hcnt != '0))
                    st_d = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (vd.keep)
                    st_d = ST_REPLAY;
                else if (ended_q)
                    st_d = ST_HEAD;
                else
                    st_d = ST_DROP;
            end
            ST_REPLAY: begin
                if (rp_q == hcnt - 1'b1)
                    st_d = ended_q ? ST_END : ST_STREAM;
            end
            ST_END:    st_d = ST_HEAD;
            ST_STREAM: if (take_m) st_d = ST_HEAD;
            ST_DROP:   if (take_m) st_d = ST_HEAD;
            default:   st_d = ST_HEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_HEAD;
            ended_q <= 1'b0;
            err_q   <= 1'b0;
            rp_q    <= '0;
            dest_q  <= '0;
            ov_q    <= 1'b0;
            oe_q    <= 1'b0;
            oerr_q  <= 1'b0;
            od_q    <= '0;
            odest_q <= '0;
        end else begin
            st_q <= st_d;
            ov_q <= 1'b0;
            oe_q <= 1'b0;
            if (clr)
                ended_q <= 1'b0;
            unique case (st_q)
                ST_HEAD: begin
                    if (take_m && (hcnt != '0)) begin
                        ended_q <= 1'b1;
                        err_q   <= rxf_err;
                    end
                end
                ST_DECIDE: begin
                    rp_q   <= '0;
                    dest_q <= vd_dest;
                end
                ST_REPLAY: begin
                    ov_q    <= 1'b1;
                    od_q    <= hb[rp_q];
                    odest_q <= dest_q;
                    rp_q    <= rp_q + 1'b1;
                end
                ST_END: begin
                    oe_q    <= 1'b1;
                    oerr_q  <= err_q;
                    odest_q <= dest_q;
                end
                ST_STREAM: begin
                    if (take_d) begin
                        ov_q    <= 1'b1;
                        od_q    <= rxf_data;
                        odest_q <= dest_q;
                    end else if (take_m) begin
                        oe_q    <= 1'b1;
                        oerr_q  <= rxf_err;
                        odest_q <= dest_q;
                    end
                end
                default: ;
            endcase
        end
    end

    assign out_valid   = ov_q;
    assign out_data    = od_q;
    assign out_end     = oe_q;
    assign out_end_err = oerr_q;
    assign out_dest    = odest_q;

    // ---------------- assertions ----------------
    // R7
    beat_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_end));

    // R1
    dis_chan_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_dest < TARGET_IDX)) |-> cfg_chan_en[out_dest]);

    // R5
    target_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_dest == TARGET_IDX)) |-> cfg_rmap_en);

    // R10
    dest_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> $stable(out_dest));

    // R10
    gap_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        out_end |=> !out_valid);

endmodule

// File: tb/spw_rx_steer_tb.sv
module spw_rx_steer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int NCH        = 4;
    localparam int DW         = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(HALF) clk = ~clk;

    logic             rxf_valid, rxf_marker, rxf_err, rxf_rd;
    logic [7:0]       rxf_data;
    logic [NCH-1:0]   c_en, c_own;
    logic [NCH*8-1:0] c_addr, c_mask;
    logic [7:0]       c_daddr, c_dmask;
    logic             c_rmap, c_prom;
    logic             out_valid, out_end, out_end_err;
    logic [7:0]       out_data;
    logic [DW-1:0]    out_dest;

    spw_rx_steer #(.NCH(NCH)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .rxf_valid     (rxf_valid),
        .rxf_data      (rxf_data),
        .rxf_marker    (rxf_marker),
        .rxf_err       (rxf_err),
        .rxf_rd        (rxf_rd),
        .cfg_chan_en   (c_en),
        .cfg_chan_own  (c_own),
        .cfg_chan_addr (c_addr),
        .cfg_chan_mask (c_mask),
        .cfg_def_addr  (c_daddr),
        .cfg_def_mask  (c_dmask),
        .cfg_rmap_en   (c_rmap),
        .cfg_promisc   (c_prom),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_end       (out_end),
        .out_end_err   (out_end_err),
        .out_dest      (out_dest)
    );

    logic [9:0]  fifo_q[$];   // {marker, err, data}
    logic [11:0] exp_q[$];    // {is_end, dest, data-or-err}
    string       tag_q[$];
    int          vectors = 0;
    int          fails   = 0;
    bit          rd_seen = 1'b0;
    bit          done    = 1'b0;

    task automatic set_cfg(input int k);
        c_en = '0; c_own = '0; c_addr = '0; c_mask = '0;
        c_daddr = 8'h00; c_dmask = 8'h00; c_rmap = 1'b0; c_prom = 1'b0;
        case (k)
            0: begin
                c_en = 4'b1111; c_own = 4'b0101;
                c_addr = {8'h00, 8'h40, 8'h00, 8'h20};
                c_mask = {8'hFF, 8'h03, 8'hFF, 8'h0F};
                c_daddr = 8'hFE; c_dmask = 8'h00; c_rmap = 1'b1;
            end
            1: begin
                c_en = 4'b1011; c_own = 4'b1111;
                c_addr = {8'h80, 8'h18, 8'h10, 8'h10};
                c_mask = {8'h7F, 8'h0F, 8'h0F, 8'h07};
                c_prom = 1'b1;
            end
            2: begin
                c_daddr = 8'h55; c_dmask = 8'h81; c_rmap = 1'b1;
            end
            default: begin
                c_en = 4'b1110;
                c_daddr = 8'h33; c_dmask = 8'h30; c_rmap = 1'b1; c_prom = 1'b1;
            end
        endcase
    endtask

    function automatic bit mhit(input logic [7:0] a, input logic [7:0] r, input logic [7:0] m);
        // R2: masked-off bits take no part
        return ((a ^ r) & ~m) == 8'h00;
    endfunction

    task automatic send_pkt(input int k, input int a);
        int         len;
        logic [7:0] b[4];
        bit         eep, rp, cmd_ok, dh, found;
        int         dest, first;
        string      tg;
        len  = a % 5;
        b[0] = a[7:0];
        b[1] = (a % 3 == 0) ? 8'h01 : (a[7:0] ^ 8'h5A);
        b[2] = (a % 2 == 1) ? 8'h4C : 8'h0C;
        b[3] = 8'(a + k);
        eep  = (a % 7 == 0);
        for (int i = 0; i < len; i++) fifo_q.push_back({1'b0, 1'b0, b[i]});
        fifo_q.push_back({1'b1, eep, 8'h00});

        dest = -1; tg = "R8";
        rp   = c_rmap && (len >= 2) && (b[1] == 8'h01);
        if (len == 0) return;                       // R8: marker alone
        if (len == 1 && !c_prom) return;            // R8: too short
        if (len == 2 && rp) return;                 // R9: RMAP needs 3
        cmd_ok = rp && (len >= 3) && b[2][6];
        dh     = mhit(b[0], c_daddr, c_dmask);
        found  = 1'b0; first = 0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (c_en[i] && (c_own[i] ? mhit(b[0], c_addr[i*8 +: 8], c_mask[i*8 +: 8]) : dh)) begin
                found = 1'b1; first = i;
            end
        end
        if (cmd_ok && dh) begin
            dest = NCH; tg = "R4";
        end else if (found) begin
            dest = first;
            tg   = c_own[first] ? "R3" : ((c_dmask != 8'h00) ? "R2" : "R1");
        end else if (cmd_ok) begin
            dest = NCH; tg = "R5";
        end else begin
            return;                                 // R6: no destination
        end
        for (int i = 0; i < len; i++) begin
            exp_q.push_back({1'b0, 3'(dest), b[i]});
            tag_q.push_back(tg);
        end
        exp_q.push_back({1'b1, 3'(dest), 7'b0, eep});   // R7 end beat, R10 same dest
        tag_q.push_back("R7");
    endtask

    task automatic check_beat(input logic [11:0] act);
        logic [11:0] e;
        string       t;
        vectors++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R6: unexpected beat got end=%0b dest=%0d data=%02h exp none",
                     act[11], act[10:8], act[7:0]);
            return;
        end
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
            fails++;
            $display("FAIL %s: got end=%0b dest=%0d data=%02h exp end=%0b dest=%0d data=%02h",
                     t, act[11], act[10:8], act[7:0], e[11], e[10:8], e[7:0]);
        end
    endtask

    // FIFO model and output monitor
    initial begin
        rxf_valid = 1'b0; rxf_data = '0; rxf_marker = 1'b0; rxf_err = 1'b0;
        forever begin
            @(negedge clk);
            if (rd_seen && fifo_q.size() > 0) fifo_q.delete(0);
            if (!rst && (out_valid || out_end))
                check_beat(out_end ? {1'b1, out_dest, 7'b0, out_end_err}
                                   : {1'b0, out_dest, out_data});
            if (!rst && fifo_q.size() > 0 && $urandom_range(3) != 0) begin
                rxf_valid  = 1'b1;
                rxf_marker = fifo_q[0][9];
                rxf_err    = fifo_q[0][8];
                rxf_data   = fifo_q[0][7:0];
            end else begin
                rxf_valid = 1'b0;
            end
            #(HALF - 1);
            rd_seen = rxf_rd;
        end
    end

    initial begin
        set_cfg(0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0 || out_end !== 1'b0) begin
            fails++;
            $display("FAIL R11: reset got valid=%0b end=%0b exp 0 0", out_valid, out_end);
        end
        rst = 1'b0;
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0 || out_end !== 1'b0) begin
            fails++;
            $display("FAIL R11: after reset got valid=%0b end=%0b exp 0 0", out_valid, out_end);
        end
        for (int k = 0; k < 4; k++) begin
            set_cfg(k);
            for (int a = 0; a < 256; a++) send_pkt(k, a);
            while (fifo_q.size() != 0) @(negedge clk);
            repeat (20) @(negedge clk);
            vectors++;
            if (exp_q.size() != 0) begin
                fails++;
                $display("FAIL R7: config %0d missing beats got %0d left exp 0", k, exp_q.size());
                exp_q.delete();
                tag_q.delete();
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule